// File: doc/BRIEF.md
# Parallel/Serial-In Serial-Out Shift Register

An eight-stage register (width set by a parameter) that either captures a full word from its parallel inputs or moves its contents one stage per clock, filling the first stage from a serial input. The last stage drives the only output, a serial bit stream. A typical use is serialising a byte: load it once, then shift it out most-significant stage first. Another use is collecting a serial stream while another agent watches the output.

An inhibit input freezes the register while the system clock keeps running. It acts as a synchronous enable sampled on the rising clock edge, so the design has no gated clock. An active-low asynchronous clear empties every stage at once and overrides everything else.

Top module: `piso_shift_reg`

## Requirements
- R1: With inhibit_i low and shift_load_i = 1, each rising clk_i edge moves every stage k to stage k+1 and places ser_i into stage 0 (stage 0 is stage A).
- R2: With inhibit_i low and shift_load_i = 0, the next rising edge copies par_i[k] into stage k for all k. Nothing changes before that edge.
- R3: During a parallel load, ser_i has no effect on any stage.
- R4: With inhibit_i high, the register keeps its contents across clock edges, whatever the other inputs do.
- R5: While rst_ni is low, every stage is zero. This takes effect at once, without waiting for a clock edge, and it overrides loads and shifts.
- R6: ser_o is the last stage, index WIDTH-1. After a load, successive shifts present par bits in the order WIDTH-1 down to 0.
- R7: After WIDTH shifts, the register holds the last WIDTH serial bits, the oldest in the last stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock, rising edge active |
| rst_ni | input | 1 | Active-low asynchronous clear |
| inhibit_i | input | 1 | High freezes the register |
| shift_load_i | input | 1 | 1 = shift, 0 = parallel load |
| ser_i | input | 1 | Serial data into stage 0 |
| par_i | input | WIDTH | Parallel data, bit k to stage k |
| ser_o | output | 1 | Last stage output |

## Verification
Three actions can meet in one cycle: the clear, a load or shift, and the inhibit. The bench lowers the clear between edges while a shift sequence is running. It keeps the clear low across edges that request a load of all ones, and it judges that the output is zero at once and stays zero. Random cycles also combine inhibit with both modes at the same time. The byte model is checked on every cycle to show that the inhibit always wins over a load or shift.

// File: rtl/piso_pkg.sv
package piso_pkg;
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } mode_e;
endpackage

// File: rtl/piso_next.sv
module piso_next
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  input  mode_e            mode_i,
  output logic [WIDTH-1:0] d_o
);
  // Each stage chooses between its upstream stage and its parallel bit.
  for (genvar k = 0; k < WIDTH; k++) begin : g_stage
    logic upstream;
    if (k == 0) begin : g_head
      assign upstream = ser_i;
    end else begin : g_body
      assign upstream = q_i[k-1];
    end
    assign d_o[k] = (mode_i == MODE_SHIFT) ? upstream : par_i[k];
  end
endmodule

// File: rtl/piso_bank.sv
module piso_bank #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end

  // R4
  hold_when_inhibited_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(q_o));

  // R5
  always @(negedge clk_i) begin
    if (!rst_ni) clear_zero_chk: assert (q_o == '0);
  end
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inhibit_i,
  input  logic             shift_load_i,
  input  logic             ser_i,
  input  logic [WIDTH-1:0] par_i,
  output logic             ser_o
);
  localparam int LAST = WIDTH - 1;

  mode_e            mode;
  logic [WIDTH-1:0] q, d;

  assign mode = shift_load_i ? MODE_SHIFT : MODE_LOAD;

  piso_next #(.WIDTH(WIDTH)) u_next (
    .q_i   (q),
    .par_i (par_i),
    .ser_i (ser_i),
    .mode_i(mode),
    .d_o   (d)
  );

  // Inhibit modelled as a synchronous enable; no gated clock.
  piso_bank #(.WIDTH(WIDTH)) u_bank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (!inhibit_i),
    .d_i   (d),
    .q_o   (q)
  );

  assign ser_o = q[LAST];

  // R2 R3
  load_captures_par_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inhibit_i && !shift_load_i) |=> q == $past(par_i));

  // R1
  shift_moves_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inhibit_i && shift_load_i) |=> q == {$past(q[LAST-1:0]), $past(ser_i)});

  // R6
  out_follows_prev_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inhibit_i && shift_load_i) |=> ser_o == $past(q[LAST-1]));
endmodule

// File: tb/piso_shift_reg_tb.sv
module piso_shift_reg_tb;
  localparam int WIDTH  = 8;
  localparam int PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             inh = 1'b1;
  logic             sl = 1'b1;
  logic             ser = 1'b0;
  logic [WIDTH-1:0] par = '0;
  logic             ser_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [WIDTH-1:0] model = '0;

  always #(PERIOD/2) clk = ~clk;

  piso_shift_reg #(.WIDTH(WIDTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .inhibit_i(inh), .shift_load_i(sl),
    .ser_i(ser), .par_i(par), .ser_o(ser_o)
  );

  function automatic logic [WIDTH-1:0] next_model(logic [WIDTH-1:0] m, logic r, logic i,
                                                  logic s, logic si, logic [WIDTH-1:0] p);
    if (!r) return '0;
    if (i)  return m;
    return s ? {m[WIDTH-2:0], si} : p;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: ser_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Called just after a rising edge, while clk is high; inputs apply at the next edge.
  task automatic cycle(string req, logic i, logic s, logic si, logic [WIDTH-1:0] p);
    inh = i; sl = s; ser = si; par = p;
    @(posedge clk);
    model = next_model(model, rst_n, i, s, si, p);
    #1;
    check(req, ser_o, model[WIDTH-1]);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: expired, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [WIDTH-1:0] byte_v;
    void'($urandom(32'd1234));
    #2;
    check("R5 reset", ser_o, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R2: load 0xA5, then shift out in order WIDTH-1..0 (R6)
    byte_v = 8'hA5;
    inh = 1'b0; sl = 1'b0; par = byte_v;
    #2 check("R2 no change before edge", ser_o, 1'b0);
    @(posedge clk); model = byte_v; #1;
    check("R2 load", ser_o, byte_v[WIDTH-1]);
    for (int k = WIDTH - 2; k >= 0; k--) begin
      cycle("R6 order", 1'b0, 1'b1, 1'b0, '0);
      check("R6 bit", ser_o, byte_v[k]);
    end

    // R3: load with serial input high and low
    cycle("R3 load ser=1", 1'b0, 1'b0, 1'b1, 8'h3C);
    cycle("R3 load ser=0", 1'b0, 1'b0, 1'b0, 8'hC3);
    for (int k = 0; k < WIDTH; k++) cycle("R3 drain", 1'b0, 1'b1, 1'b0, '0);

    // R7: serial fill 1,0,1,1,0,0,1,0 then observe
    byte_v = 8'b1011_0010;
    for (int k = WIDTH - 1; k >= 0; k--) cycle("R7 fill", 1'b0, 1'b1, byte_v[k], '0);
    check("R7 oldest at out", ser_o, byte_v[WIDTH-1]);

    // R4: inhibit holds against load and shift
    cycle("R4 hold load", 1'b1, 1'b0, 1'b1, 8'h00);
    cycle("R4 hold shift", 1'b1, 1'b1, 1'b0, 8'hFF);
    cycle("R4 resume", 1'b0, 1'b1, 1'b0, '0);

    // R5: clear mid-shift, held across load requests
    cycle("R5 preload", 1'b0, 1'b0, 1'b0, 8'hFF);
    cycle("R5 shift", 1'b0, 1'b1, 1'b1, '0);
    rst_n = 1'b0; model = '0;
    #2 check("R5 async clear", ser_o, 1'b0);
    for (int k = 0; k < 3; k++) cycle("R5 override load", 1'b0, 1'b0, 1'b1, 8'hFF);
    rst_n = 1'b1;
    cycle("R5 after release", 1'b1, 1'b1, 1'b1, '0);

    // Random mix (R1 R2 R4)
    for (int n = 0; n < 600; n++) begin
      cycle("R1/R2/R4 random", ($urandom % 4) == 0, $urandom % 2, $urandom % 2,
            WIDTH'($urandom));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule